// File: doc/BRIEF.md
# Serial Configuration Chain Receiver

This block is the receiving end of a serial configuration chain. An external source drives a configuration clock and a data line. The block samples one bit on every rising edge of that clock. It searches the incoming stream for a sync word and then reads a 24-bit length field. After that it takes the configuration payload. The first part of the payload belongs to this device: it is packed into frames of a configurable width and handed to the local configuration memory with a one-cycle strobe. Everything else is repeated on a pass-through output for the next device in the chain. That covers the stream before sync, the sync word, the length field and all payload bits beyond the local quota.

The pass-through output is re-timed onto the falling clock edge. The next device therefore sees each forwarded bit half a period after it arrived here, and can sample it on the following rising edge. Bits are taken only while the three mode inputs select slave serial operation (all ones) and the init-ready input is high. When the length count is reached, a sticky done flag rises and further input is ignored. An active-low reset asserts asynchronously, releases through a two-stage synchronizer, and returns the block to sync search.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is asserted and right after it, dout is 1, frame_vld is 0, frame_data is 0 and cfg_done is 0.
- R2: A rising edge takes a bit only when mode equals 3'b111 and init_rdy is 1. Any other edge has no effect: dout keeps its value and the protocol does not advance.
- R3: The block searches for the sync word until its last 8 taken bits, oldest first, equal SYNC_PAT (default 8'hB5). Partial or overlapping matches before that point are only forwarded.
- R4: The 24 taken bits after the sync word are the payload length L, most significant bit first.
- R5: The first min(L, FRAMES*FRAME_W) payload bits are stored MSB first. Each group of FRAME_W bits appears on frame_data, with the earliest bit in the MSB, one cycle after the edge that took its last bit. frame_vld is high for exactly that one cycle. At most FRAMES frames are delivered.
- R6: Bits taken during sync search and length reading, and payload bits beyond the local quota, are forwarded on dout. While a payload bit is being stored, dout is 1.
- R7: dout changes only on the falling edge that follows the rising edge that took the bit, and it holds through the next rising edge.
- R8: cfg_done rises after the edge that takes the L-th payload bit, or the last length bit when L is 0. It then stays high, all later bits are ignored, and dout returns to 1.
- R9: If L stops partway through a frame, no strobe is issued for the incomplete frame.
- R10: Asserting reset in the middle of a stream at once clears cfg_done and frame_vld and drives dout to 1. Once reset is released, a new sync word is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Externally driven configuration clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| din | input | 1 | Serial configuration data |
| mode | input | 3 | Mode select, 3'b111 enables slave serial |
| init_rdy | input | 1 | High when the chain is ready for configuration |
| dout | output | 1 | Pass-through data, updated on the falling edge |
| frame_data | output | FRAME_W | Last completed local frame |
| frame_vld | output | 1 | One-cycle strobe for each completed frame |
| cfg_done | output | 1 | Sticky flag, length count reached |

## Verification
The bench probes the following cases:
- A sync word preceded by a partial, overlapping match. A window compare that resets wrongly would miss the sync word or lock on early.
- Gated edges (wrong mode, or init-ready low) inserted inside the sync word. A design that ignores gating would shift those bits in.
- Lengths that are longer than, shorter than, exactly equal to and zero relative to the local quota. Off-by-one counting would show here as an extra or missing strobe, a strobe for a partial frame, a late done flag, or stored bits leaking onto dout.
- dout checked both just after the rising edge and just after the falling edge. An output re-timed on the wrong edge fails one of the two checks.
- A mid-stream reset, which must discard the partially read length.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [2:0] SLAVE_MODE = 3'b111;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LEN  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } cfgp_state_e;
endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
#(
  parameter int              SYNC_W     = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB5,
  parameter int              LEN_W      = 24,
  parameter int              LOCAL_BITS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [2:0] mode,
  input  logic       init_rdy,
  output logic       take,
  output logic       fwd_en,
  output logic       store_en,
  output logic       st_done
);
  localparam int LC_W = $clog2(LEN_W);
  localparam logic [LEN_W-1:0] QUOTA = LEN_W'(LOCAL_BITS);
  localparam logic [LC_W-1:0]  LAST_LEN_BIT = LC_W'(LEN_W - 1);

  cfgp_state_e       state_q, state_n;
  logic [SYNC_W-1:0] win_q, win_n;
  logic [LC_W-1:0]   lcnt_q, lcnt_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [LEN_W-1:0]  dcnt_q, dcnt_n;

  assign take = (mode == SLAVE_MODE) && init_rdy && (state_q != ST_DONE);

  always_comb begin
    state_n  = state_q;
    win_n    = win_q;
    lcnt_n   = lcnt_q;
    len_n    = len_q;
    dcnt_n   = dcnt_q;
    fwd_en   = 1'b0;
    store_en = 1'b0;
    if (take) begin
      case (state_q)
        ST_HUNT: begin
          fwd_en = 1'b1;
          win_n  = {win_q[SYNC_W-2:0], din};
          if (win_n == SYNC_PAT) begin
            state_n = ST_LEN;
            lcnt_n  = '0;
          end
        end
        ST_LEN: begin
          fwd_en = 1'b1;
          len_n  = {len_q[LEN_W-2:0], din};
          lcnt_n = lcnt_q + 1'b1;
          if (lcnt_q == LAST_LEN_BIT) begin
            dcnt_n  = '0;
            state_n = (len_n == '0) ? ST_DONE : ST_DATA;
          end
        end
        ST_DATA: begin
          dcnt_n = dcnt_q + 1'b1;
          if (dcnt_q < QUOTA) store_en = 1'b1;
          else                fwd_en   = 1'b1;
          if (dcnt_n == len_q) state_n = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      win_q   <= '0;
      lcnt_q  <= '0;
      len_q   <= '0;
      dcnt_q  <= '0;
    end else if (take) begin
      state_q <= state_n;
      win_q   <= win_n;
      lcnt_q  <= lcnt_n;
      len_q   <= len_n;
      dcnt_q  <= dcnt_n;
    end
  end

  assign st_done = (state_q == ST_DONE);

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(state_q));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> st_done);

  // R8
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> ($past(state_q) == ST_LEN || $past(state_q) == ST_DATA));

  // R6
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_en && store_en));
endmodule

// File: rtl/cfgp_frame_shift.sv
module cfgp_frame_shift #(
  parameter int FRAME_W = 16,
  parameter int FRAMES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_vld
);
  localparam int BC_W = $clog2(FRAME_W);
  localparam int FC_W = $clog2(FRAMES + 1);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_n;
  logic [BC_W-1:0]    bcnt_q, bcnt_n;
  logic [FRAME_W-1:0] data_q;
  logic               vld_q, vld_n;
  logic               frame_end;
  logic [FC_W-1:0]    emitted_q;

  assign frame_end = shift_en && (bcnt_q == LAST_BIT);

  always_comb begin
    sr_n   = {sr_q[FRAME_W-2:0], bit_in};
    bcnt_n = frame_end ? '0 : bcnt_q + 1'b1;
    vld_n  = frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (shift_en) begin
      sr_q   <= sr_n;
      bcnt_q <= bcnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (frame_end) data_q <= sr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     emitted_q <= '0;
    else if (vld_q) emitted_q <= emitted_q + 1'b1;
  end

  assign frame_data = data_q;
  assign frame_vld  = vld_q;

  // R5
  frame_quota_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> (emitted_q < FC_W'(FRAMES)));

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);
endmodule

// File: rtl/cfgp_fwd.sv
module cfgp_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic fwd_en,
  input  logic din,
  input  logic st_done,
  output logic dout
);
  logic fwd_q, fwd_n;
  logic out_q;

  always_comb begin
    if (st_done)   fwd_n = 1'b1;
    else if (take) fwd_n = fwd_en ? din : 1'b1;
    else           fwd_n = fwd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= 1'b1;
    else        fwd_q <= fwd_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= fwd_q;
  end

  assign dout = out_q;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && $past(st_done)) |-> dout);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int FRAME_W   = 16,
  parameter int FRAMES    = 4,
  parameter int SYNC_W    = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB5,
  parameter int LEN_W     = 24,
  parameter int RST_STAGES = 2
) (
  input  logic               cfg_clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic [2:0]         mode,
  input  logic               init_rdy,
  output logic               dout,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_vld,
  output logic               cfg_done
);
  localparam int LOCAL_BITS = FRAME_W * FRAMES;

  logic rst_n_s;
  logic take, fwd_en, store_en, st_done;

  cfgp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (cfg_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cfgp_ctrl #(
    .SYNC_W     (SYNC_W),
    .SYNC_PAT   (SYNC_PAT),
    .LEN_W      (LEN_W),
    .LOCAL_BITS (LOCAL_BITS)
  ) u_ctrl (
    .clk      (cfg_clk),
    .rst_n    (rst_n_s),
    .din      (din),
    .mode     (mode),
    .init_rdy (init_rdy),
    .take     (take),
    .fwd_en   (fwd_en),
    .store_en (store_en),
    .st_done  (st_done)
  );

  cfgp_frame_shift #(.FRAME_W(FRAME_W), .FRAMES(FRAMES)) u_frame (
    .clk        (cfg_clk),
    .rst_n      (rst_n_s),
    .shift_en   (store_en),
    .bit_in     (din),
    .frame_data (frame_data),
    .frame_vld  (frame_vld)
  );

  cfgp_fwd u_fwd (
    .clk     (cfg_clk),
    .rst_n   (rst_n_s),
    .take    (take),
    .fwd_en  (fwd_en),
    .din     (din),
    .st_done (st_done),
    .dout    (dout)
  );

  assign cfg_done = st_done;
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb_top;
  localparam int FW = 16;
  localparam int NF = 4;
  localparam int LOCAL = FW * NF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b1;
  logic [2:0]    mode = 3'b111;
  logic          init_rdy = 1'b0;
  logic          dout;
  logic [FW-1:0] frame_data;
  logic          frame_vld;
  logic          cfg_done;

  int total = 0;
  int bad = 0;
  int nvld = 0;
  int cyc = 0;

  // behavioural reference
  int            m_st;
  logic [7:0]    m_win;
  int            m_lcnt;
  logic [23:0]   m_len;
  int            m_dcnt;
  logic [FW-1:0] m_sr;
  int            m_fbits;
  logic          m_vld, m_fwd, m_fwd_prev, m_done;
  logic [FW-1:0] m_data;

  serial_cfg_port dut_i (
    .cfg_clk(clk), .rst_n(rst_n), .din(din), .mode(mode), .init_rdy(init_rdy),
    .dout(dout), .frame_data(frame_data), .frame_vld(frame_vld), .cfg_done(cfg_done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_win = '0; m_lcnt = 0; m_len = '0; m_dcnt = 0;
    m_sr = '0; m_fbits = 0; m_vld = 0; m_fwd = 1; m_fwd_prev = 1;
    m_done = 0; m_data = '0;
  endtask

  task automatic model_step(input logic b, input logic [2:0] m, input logic ir);
    m_vld = 0;
    m_fwd_prev = m_fwd;
    if (m_st == 3) m_fwd = 1;
    else if (m == 3'b111 && ir) begin
      if (m_st == 0) begin
        m_fwd = b;
        m_win = {m_win[6:0], b};
        if (m_win == 8'hB5) begin m_st = 1; m_lcnt = 0; end
      end else if (m_st == 1) begin
        m_fwd = b;
        m_len = {m_len[22:0], b};
        m_lcnt++;
        if (m_lcnt == 24) begin
          m_dcnt = 0;
          m_st = (m_len == 0) ? 3 : 2;
        end
      end else begin
        if (m_dcnt < LOCAL) begin
          m_fwd = 1;
          m_sr = {m_sr[FW-2:0], b};
          m_fbits++;
          if (m_fbits == FW) begin m_vld = 1; m_data = m_sr; m_fbits = 0; end
        end else m_fwd = b;
        m_dcnt++;
        if (m_dcnt == int'(m_len)) m_st = 3;
      end
    end
    m_done = (m_st == 3);
  endtask

  task automatic clk_bit(input logic b, input logic [2:0] m, input logic ir);
    din = b; mode = m; init_rdy = ir;
    @(posedge clk);
    model_step(b, m, ir);
    #1;
    check("R5 frame_vld", frame_vld, m_vld);
    check("R5 frame_data", frame_data, m_data);
    check("R8 cfg_done", cfg_done, m_done);
    check("R7 dout before fall", dout, m_fwd_prev);
    if (frame_vld === 1'b1) nvld++;
    #2;
    check("R6 dout after fall", dout, m_fwd);
  endtask

  task automatic send(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(val[i], 3'b111, 1'b1);
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) clk_bit(1'($urandom_range(0, 1)), 3'b111, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    #1;
    repeat (2) @(posedge clk);
    #1;
    // R1
    check("R1 dout", dout, 1'b1);
    check("R1 frame_vld", frame_vld, 1'b0);
    check("R1 frame_data", frame_data, '0);
    check("R1 cfg_done", cfg_done, 1'b0);
    #2;
    rst_n = 1;
    repeat (3) clk_bit(1'b1, 3'b111, 1'b0);
    nvld = 0;
  endtask

  initial begin
    model_reset();
    @(posedge clk); #3;
    do_reset();

    // R2: forward a 0, then gated edges must leave dout and progress alone
    clk_bit(1'b0, 3'b111, 1'b1);
    clk_bit(1'b1, 3'b110, 1'b1);
    clk_bit(1'b1, 3'b111, 1'b0);
    clk_bit(1'b1, 3'b011, 1'b1);
    check("R2 dout held under gating", dout, 1'b0);
    // R3: partial overlapping match, then sync with a gated edge inside
    send(32'hB, 4);
    send(32'hB, 4);
    clk_bit(1'b0, 3'b101, 1'b1);
    send(32'h5, 4);
    check("R3 no done during hunt", cfg_done, 1'b0);
    // R4: length 80 = full quota plus 16 forwarded bits
    send(32'd80, 24);
    send_rand(80);
    check("R3 R4 R5 frame count", nvld, NF);
    check("R8 done after length", cfg_done, 1'b1);
    send_rand(10);
    check("R8 dout idle after done", dout, 1'b1);

    // R9: length ends inside the third frame
    do_reset();
    send(32'hB5, 8);
    send(32'd40, 24);
    send_rand(40);
    check("R9 partial frame not strobed", nvld, 2);
    check("R9 done", cfg_done, 1'b1);

    // R8: zero length finishes right after the length field
    do_reset();
    send(32'hB5, 8);
    send(32'd0, 23);
    check("R8 not done before last length bit", cfg_done, 1'b0);
    send(32'd0, 1);
    check("R8 zero length done", cfg_done, 1'b1);
    check("R8 zero length no frames", nvld, 0);

    // R10: reset in the middle of the length field
    do_reset();
    send(32'hB5, 8);
    send(32'h3, 10);
    rst_n = 0;
    model_reset();
    #1;
    check("R10 dout after mid reset", dout, 1'b1);
    check("R10 done after mid reset", cfg_done, 1'b0);
    check("R10 vld after mid reset", frame_vld, 1'b0);
    do_reset();
    send(32'h0, 14);
    check("R10 stale length discarded", cfg_done, 1'b0);
    send(32'hB5, 8);
    send(32'd64, 24);
    send_rand(64);
    check("R5 exact quota frames", nvld, NF);
    check("R8 exact quota done", cfg_done, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule